// File: doc/BRIEF.md
# Sample Phase Timing Programmer

This block sets up the receive-sample timing of a storage-card host interface. A request gives a controller index, a bus timing mode and, when wanted, an explicit sample phase. From a built-in table of drive phase, sample delay and a permitted sample-phase window for each controller and mode, the block picks the sample phase. It then works out two phase-dependent flags and builds three register words.

The words go out through a one-cycle-per-write port made of address, data and a write strobe. The order never changes. First, clocking is switched off with a zero clock-control word, and a short gap follows. Next come the extended timing word, the shift-enable word and the clock-control word with clocking on. A settle interval follows, and after it `done` pulses for one cycle.

A request naming a controller or mode that has no table entry raises `err` for one cycle and writes nothing. Requests are taken only while the block is idle. Card command handling and clock generation are outside the block.

Top module: `phase_timing_prog`

## Requirements
- R1: After reset the block is idle: `busy`, `wr_en`, `done` and `err` are low, and no write appears until a request is accepted.
- R2: With `req_ovr_en` low, the sample phase is floor((window max + window min) / 2) of the selected table entry.
- R3: With `req_ovr_en` high, the sample phase is `req_ovr_phase` (0..31), whatever the table window holds.
- R4: The use-delay flag is set only in mode 6 (SDR104) with a sample phase of 11 to 14 inclusive. It appears as bit 13 of the final clock-control word.
- R5: The shift-enable flag is set only in mode 5 (SDR50) or mode 6 with a sample phase of 4 to 12 inclusive. It is written as bit 0 of the shift-enable word (address 2), and bits 31:1 of that word are zero.
- R6: The extended timing word (address 1) holds the sample phase in bits 20:16, the drive phase in bits 25:21 and the sample delay in bits 30:26. All other bits are zero.
- R7: The first write of a sequence is a zero to the clock-control address (0). The last write goes to address 0 with the value 7 in bits 11:8, the use-delay flag in bit 13, the clock-enable bit 16 set and all other bits zero.
- R8: Writes occur on consecutive-state cycles in the order address 0, then a gap of exactly SHORT_WAIT idle cycles, then addresses 1, 2 and 0 on three back-to-back cycles. A settle interval of exactly SETTLE_WAIT cycles follows.
- R9: `done` is high for exactly one cycle, right after the settle interval. `busy` is high from the cycle after acceptance through the `done` cycle and is low the cycle after.
- R10: A request presented while `busy` is high is ignored. It neither alters the running sequence nor starts another one.
- R11: A controller index with no table (0, or 3 and above) or a mode with no entry (controller 2 mode 1, modes 7 and above) gives a one-cycle `err` with `busy` high, with no write, and the block then returns to idle. Valid entries are controller 1 modes 0..6 and controller 2 modes 0 and 2..6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_ctrl | input | CTRL_W | Controller index |
| req_mode | input | MODE_W | Bus timing mode (0 legacy, 1 MMC high speed, 2 SD high speed, 3 SDR12, 4 SDR25, 5 SDR50, 6 SDR104) |
| req_ovr_en | input | 1 | Use the explicit sample phase |
| req_ovr_phase | input | 5 | Explicit sample phase |
| busy | output | 1 | Sequence or error report in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | One-cycle invalid-request pulse |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | 2 | Write address: 0 clock control, 1 extended timing, 2 shift enable |
| wr_data | output | 32 | Write data |

## Verification
The assertions assume a synchronous reset and requests whose fields are stable in the cycle `req_valid` is sampled; beyond that they depend only on the block's own write ordering. The bench always holds request fields steady around the accepting edge. It issues its deliberately ignored request only while a sequence is running. It steps the sample phase across both flag windows at their edges (3, 4, 11, 12, 13, 14, 15) in SDR50 and SDR104, and through each class of invalid controller and mode.

// File: rtl/phase_timing_pkg.sv
package phase_timing_pkg;

   localparam int WORD_W     = 32;
   localparam int FLD_W      = 5;
   localparam int ADR_W      = 2;

   localparam logic [ADR_W-1:0] ADR_CLKCTL = 2'd0;
   localparam logic [ADR_W-1:0] ADR_EXT    = 2'd1;
   localparam logic [ADR_W-1:0] ADR_SHIFT  = 2'd2;

   localparam int MODE_SDR50  = 5;
   localparam int MODE_SDR104 = 6;

   localparam int SHIFT_LO = 4;
   localparam int SHIFT_HI = 12;
   localparam int DLY_LO   = 11;
   localparam int DLY_HI   = 14;

   localparam logic [3:0] CLK_DIV_VAL = 4'd7;
   localparam int POS_DIV    = 8;
   localparam int POS_USEDLY = 13;
   localparam int POS_CLKEN  = 16;
   localparam int POS_PHASE  = 16;
   localparam int POS_DRV    = 21;
   localparam int POS_DLY    = 26;

   typedef struct packed {
      logic             valid;
      logic [FLD_W-1:0] drv;
      logic [FLD_W-1:0] dly;
      logic [FLD_W-1:0] pmax;
      logic [FLD_W-1:0] pmin;
   } tim_ent_t;

   typedef enum logic [3:0] {
      ST_IDLE, ST_WR_OFF, ST_GAP, ST_WR_EXT, ST_WR_SHIFT,
      ST_WR_ON, ST_SETTLE, ST_DONE, ST_ERR
   } seq_st_t;

   function automatic tim_ent_t mk(input int d, input int s, input int hi, input int lo);
      tim_ent_t e;
      e.valid = 1'b1;
      e.drv   = FLD_W'(d);
      e.dly   = FLD_W'(s);
      e.pmax  = FLD_W'(hi);
      e.pmin  = FLD_W'(lo);
      return e;
   endfunction

   function automatic tim_ent_t lookup(input int ctrl, input int mode);
      tim_ent_t e;
      e = '0;
      if (ctrl == 1) begin
         case (mode)
            0: e = mk(7, 0, 15, 15);
            1: e = mk(6, 0, 4, 4);
            2: e = mk(6, 0, 3, 3);
            3: e = mk(6, 0, 15, 15);
            4: e = mk(6, 0, 2, 2);
            5: e = mk(4, 0, 11, 0);
            6: e = mk(6, 4, 15, 0);
            default: e = '0;
         endcase
      end else if (ctrl == 2) begin
         case (mode)
            0: e = mk(7, 0, 15, 15);
            2: e = mk(6, 0, 15, 15);
            3: e = mk(6, 0, 15, 15);
            4: e = mk(6, 0, 0, 0);
            5: e = mk(4, 0, 12, 0);
            6: e = mk(5, 4, 15, 0);
            default: e = '0;
         endcase
      end
      return e;
   endfunction

endpackage

// File: rtl/phase_timing_table.sv
module phase_timing_table
   import phase_timing_pkg::*;
#(
   parameter int CTRL_W = 2,
   parameter int MODE_W = 4
) (
   input  logic [CTRL_W-1:0] ctrl,
   input  logic [MODE_W-1:0] mode,
   output tim_ent_t          ent
);
   always_comb ent = lookup(int'(ctrl), int'(mode));
endmodule

// File: rtl/phase_timing_words.sv
module phase_timing_words
   import phase_timing_pkg::*;
#(
   parameter int MODE_W = 4
) (
   input  tim_ent_t          ent,
   input  logic [MODE_W-1:0] mode,
   input  logic              ovr_en,
   input  logic [FLD_W-1:0]  ovr_phase,
   output logic [WORD_W-1:0] ext_word,
   output logic [WORD_W-1:0] shift_word,
   output logic [WORD_W-1:0] clkon_word
);
   logic [FLD_W:0]   win_sum;
   logic [FLD_W-1:0] phase;
   logic             is_fast, is_top, en_shift, use_dly;

   always_comb begin
      win_sum  = {1'b0, ent.pmax} + {1'b0, ent.pmin};
      phase    = ovr_en ? ovr_phase : win_sum[FLD_W:1];
      is_top   = (int'(mode) == MODE_SDR104);
      is_fast  = is_top || (int'(mode) == MODE_SDR50);
      en_shift = is_fast && (int'(phase) >= SHIFT_LO) && (int'(phase) <= SHIFT_HI);
      use_dly  = is_top && (int'(phase) >= DLY_LO) && (int'(phase) <= DLY_HI);

      ext_word = '0;
      ext_word[POS_PHASE +: FLD_W] = phase;
      ext_word[POS_DRV   +: FLD_W] = ent.drv;
      ext_word[POS_DLY   +: FLD_W] = ent.dly;

      shift_word    = '0;
      shift_word[0] = en_shift;

      clkon_word = '0;
      clkon_word[POS_DIV +: 4]  = CLK_DIV_VAL;
      clkon_word[POS_USEDLY]    = use_dly;
      clkon_word[POS_CLKEN]     = 1'b1;
   end
endmodule

// File: rtl/phase_timing_seq.sv
module phase_timing_seq
   import phase_timing_pkg::*;
#(
   parameter int SHORT_WAIT  = 8,
   parameter int SETTLE_WAIT = 100000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_ok,
   input  logic [WORD_W-1:0] ext_word,
   input  logic [WORD_W-1:0] shift_word,
   input  logic [WORD_W-1:0] clkon_word,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              wr_en,
   output logic [ADR_W-1:0]  wr_addr,
   output logic [WORD_W-1:0] wr_data
);
   localparam int MAX_WAIT = (SHORT_WAIT > SETTLE_WAIT) ? SHORT_WAIT : SETTLE_WAIT;
   localparam int CNT_W    = $clog2(MAX_WAIT + 1);

   seq_st_t           st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] ext_q, shift_q, clkon_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cnt_q   <= '0;
         ext_q   <= '0;
         shift_q <= '0;
         clkon_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (req_valid) begin
               if (req_ok) begin
                  st_q    <= ST_WR_OFF;
                  ext_q   <= ext_word;
                  shift_q <= shift_word;
                  clkon_q <= clkon_word;
               end else begin
                  st_q <= ST_ERR;
               end
            end
            ST_WR_OFF: begin
               st_q  <= ST_GAP;
               cnt_q <= CNT_W'(SHORT_WAIT - 1);
            end
            ST_GAP: begin
               if (cnt_q == '0) st_q <= ST_WR_EXT;
               else             cnt_q <= cnt_q - 1'b1;
            end
            ST_WR_EXT:   st_q <= ST_WR_SHIFT;
            ST_WR_SHIFT: st_q <= ST_WR_ON;
            ST_WR_ON: begin
               st_q  <= ST_SETTLE;
               cnt_q <= CNT_W'(SETTLE_WAIT - 1);
            end
            ST_SETTLE: begin
               if (cnt_q == '0) st_q <= ST_DONE;
               else             cnt_q <= cnt_q - 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      busy    = (st_q != ST_IDLE);
      done    = (st_q == ST_DONE);
      err     = (st_q == ST_ERR);
      wr_en   = 1'b0;
      wr_addr = ADR_CLKCTL;
      wr_data = '0;
      case (st_q)
         ST_WR_OFF:   begin wr_en = 1'b1; end
         ST_WR_EXT:   begin wr_en = 1'b1; wr_addr = ADR_EXT;   wr_data = ext_q;   end
         ST_WR_SHIFT: begin wr_en = 1'b1; wr_addr = ADR_SHIFT; wr_data = shift_q; end
         ST_WR_ON:    begin wr_en = 1'b1; wr_data = clkon_q; end
         default: ;
      endcase
   end
endmodule

// File: rtl/phase_timing_prog.sv
module phase_timing_prog
   import phase_timing_pkg::*;
#(
   parameter int CTRL_W      = 2,
   parameter int MODE_W      = 4,
   parameter int SHORT_WAIT  = 8,
   parameter int SETTLE_WAIT = 100000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [CTRL_W-1:0] req_ctrl,
   input  logic [MODE_W-1:0] req_mode,
   input  logic              req_ovr_en,
   input  logic [4:0]        req_ovr_phase,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              wr_en,
   output logic [1:0]        wr_addr,
   output logic [31:0]       wr_data
);
   if (SHORT_WAIT < 1) begin : g_bad_short
      $error("SHORT_WAIT must be at least 1");
   end
   if (SETTLE_WAIT < 1) begin : g_bad_settle
      $error("SETTLE_WAIT must be at least 1");
   end
   if (CTRL_W < 2 || MODE_W < 3 || CTRL_W > 16 || MODE_W > 16) begin : g_bad_width
      $error("CTRL_W must be 2..16 and MODE_W 3..16");
   end

   tim_ent_t          ent;
   logic [WORD_W-1:0] ext_word, shift_word, clkon_word;

   phase_timing_table #(.CTRL_W(CTRL_W), .MODE_W(MODE_W)) i_table (
      .ctrl (req_ctrl),
      .mode (req_mode),
      .ent  (ent)
   );

   phase_timing_words #(.MODE_W(MODE_W)) i_words (
      .ent        (ent),
      .mode       (req_mode),
      .ovr_en     (req_ovr_en),
      .ovr_phase  (req_ovr_phase),
      .ext_word   (ext_word),
      .shift_word (shift_word),
      .clkon_word (clkon_word)
   );

   phase_timing_seq #(.SHORT_WAIT(SHORT_WAIT), .SETTLE_WAIT(SETTLE_WAIT)) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ok     (ent.valid),
      .ext_word   (ext_word),
      .shift_word (shift_word),
      .clkon_word (clkon_word),
      .busy       (busy),
      .done       (done),
      .err        (err),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data)
   );
endmodule

// File: rtl/phase_timing_chk.sv
module phase_timing_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        done,
   input logic        err,
   input logic        wr_en,
   input logic [1:0]  wr_addr,
   input logic [31:0] wr_data
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !wr_en && !done && !err); // R1
   AST_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) && !err |-> wr_en && wr_addr == 2'd0 && wr_data == 32'd0); // R7
   AST_EXT_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_addr == 2'd1 |-> wr_data[15:0] == 16'd0 && !wr_data[31]); // R6
   AST_SHIFT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_addr == 2'd2 |-> wr_data[31:1] == 31'd0); // R5
   AST_EXT_THEN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_addr == 2'd1 |=> wr_en && wr_addr == 2'd2); // R8
   AST_SHIFT_THEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_addr == 2'd2 |=> wr_en && wr_addr == 2'd0 && wr_data[16]
         && wr_data[11:8] == 4'd7); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy); // R9
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !wr_en ##1 !err && !busy); // R11
endmodule

bind phase_timing_prog phase_timing_chk i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .done    (done),
   .err     (err),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data)
);

// File: tb/test_phase_timing_prog.sv
module test_phase_timing_prog;
   localparam int CLK_PERIOD = 10;
   localparam int SHORT      = 3;
   localparam int SETTLE     = 6;

   typedef struct {
      bit          busy;
      bit          wr;
      bit          done;
      bit          err;
      bit [1:0]    addr;
      bit [31:0]   data;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_ctrl = '0;
   logic [3:0]  req_mode = '0;
   logic        req_ovr_en = 1'b0;
   logic [4:0]  req_ovr_phase = '0;
   logic        busy, done, err, wr_en;
   logic [1:0]  wr_addr;
   logic [31:0] wr_data;

   int   n_checks = 0;
   int   n_errors = 0;
   bit   finished = 1'b0;
   exp_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   phase_timing_prog #(.SHORT_WAIT(SHORT), .SETTLE_WAIT(SETTLE)) i_phase_timing_prog (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctrl(req_ctrl),
      .req_mode(req_mode), .req_ovr_en(req_ovr_en), .req_ovr_phase(req_ovr_phase),
      .busy(busy), .done(done), .err(err), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // spec table: returns valid, drive, delay, window max, window min
   task automatic spec(input int c, input int m, output bit v, output int d,
                       output int s, output int hi, output int lo);
      v = 1; d = 0; s = 0; hi = 0; lo = 0;
      if (c == 1 && m == 0)      begin d = 7; hi = 15; lo = 15; end
      else if (c == 1 && m == 1) begin d = 6; hi = 4;  lo = 4;  end
      else if (c == 1 && m == 2) begin d = 6; hi = 3;  lo = 3;  end
      else if (c == 1 && m == 3) begin d = 6; hi = 15; lo = 15; end
      else if (c == 1 && m == 4) begin d = 6; hi = 2;  lo = 2;  end
      else if (c == 1 && m == 5) begin d = 4; hi = 11; lo = 0;  end
      else if (c == 1 && m == 6) begin d = 6; s = 4; hi = 15; lo = 0; end
      else if (c == 2 && m == 0) begin d = 7; hi = 15; lo = 15; end
      else if (c == 2 && (m == 2 || m == 3)) begin d = 6; hi = 15; lo = 15; end
      else if (c == 2 && m == 4) begin d = 6; end
      else if (c == 2 && m == 5) begin d = 4; hi = 12; end
      else if (c == 2 && m == 6) begin d = 5; s = 4; hi = 15; end
      else v = 0;
   endtask

   function automatic exp_t ent(input bit b, input bit w, input bit dn, input bit e,
                                input int a, input int dat, input string tag);
      exp_t x;
      x.busy = b; x.wr = w; x.done = dn; x.err = e;
      x.addr = 2'(a); x.data = 32'(dat); x.tag = tag;
      return x;
   endfunction

   task automatic push_expected(input int c, input int m, input bit ov, input int ovp);
      bit v; int d, s, hi, lo, ph, sh, ud;
      spec(c, m, v, d, s, hi, lo);
      if (!v) begin
         q.push_back(ent(1, 0, 0, 1, 0, 0, "R11"));
         return;
      end
      ph = ov ? ovp : (hi + lo) / 2;
      sh = ((m == 5 || m == 6) && ph >= 4 && ph <= 12) ? 1 : 0;
      ud = (m == 6 && ph >= 11 && ph <= 14) ? 1 : 0;
      q.push_back(ent(1, 1, 0, 0, 0, 0, "R7"));
      for (int i = 0; i < SHORT; i++) q.push_back(ent(1, 0, 0, 0, 0, 0, "R8"));
      q.push_back(ent(1, 1, 0, 0, 1, (ph << 16) | (d << 21) | (s << 26), ov ? "R3" : "R2"));
      q.push_back(ent(1, 1, 0, 0, 2, sh, "R5"));
      q.push_back(ent(1, 1, 0, 0, 0, (7 << 8) | (ud << 13) | (1 << 16), "R4"));
      for (int i = 0; i < SETTLE; i++) q.push_back(ent(1, 0, 0, 0, 0, 0, "R8"));
      q.push_back(ent(1, 0, 1, 0, 0, 0, "R9"));
   endtask

   task automatic do_req(input int c, input int m, input bit ov, input int ovp);
      wait (q.size() == 0);
      @(negedge clk);
      req_valid = 1'b1; req_ctrl = 2'(c); req_mode = 4'(m);
      req_ovr_en = ov; req_ovr_phase = 5'(ovp);
      @(posedge clk);
      #1;
      push_expected(c, m, ov, ovp);
      req_valid = 1'b0;
   endtask

   // per-cycle comparison against the reference queue
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            exp_t e;
            if (q.size() != 0) e = q.pop_front();
            else e = ent(0, 0, 0, 0, 0, 0, "R1");
            chk(busy == e.busy,  e.tag, "busy",  32'(busy),  32'(e.busy));
            chk(wr_en == e.wr,   e.tag, "wr_en", 32'(wr_en), 32'(e.wr));
            chk(done == e.done,  e.tag, "done",  32'(done),  32'(e.done));
            chk(err == e.err,    e.tag, "err",   32'(err),   32'(e.err));
            if (e.wr) begin
               chk(wr_addr == e.addr, e.tag, "wr_addr", 32'(wr_addr), 32'(e.addr));
               chk(wr_data == e.data, e.tag, "wr_data", wr_data, e.data);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++; n_errors++;
         $display("FAIL watchdog: actual timeout expected end of run");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);              // R1 idle after reset
      do_req(1, 0, 0, 0);                     // R2 legacy: phase 15
      do_req(1, 5, 0, 0);                     // R2 R5 SDR50 default phase 5
      do_req(1, 6, 0, 0);                     // R2 R5 SDR104 default 7
      do_req(2, 6, 0, 0);                     // second controller
      do_req(2, 5, 0, 0);
      do_req(1, 6, 1, 3);                     // R3 edge below shift
      do_req(1, 6, 1, 4);                     // R5 lower edge
      do_req(1, 6, 1, 11);                    // R4 lower edge
      do_req(1, 6, 1, 12);                    // R4 R5 both
      do_req(1, 6, 1, 13);
      do_req(1, 6, 1, 14);                    // R4 upper edge
      do_req(1, 6, 1, 15);
      do_req(1, 6, 1, 31);                    // R3 beyond window
      do_req(1, 5, 1, 12);                    // R4 not in SDR50
      do_req(1, 5, 1, 13);
      do_req(1, 4, 1, 8);                     // no flags in SDR25
      do_req(2, 4, 0, 0);
      do_req(0, 0, 0, 0);                     // R11 controller 0
      do_req(3, 6, 0, 0);                     // R11 controller 3
      do_req(2, 1, 0, 0);                     // R11 empty entry
      do_req(1, 7, 0, 0);                     // R11 mode 7
      do_req(1, 12, 0, 0);                    // R11 mode 12
      // R10: a request arriving while busy is ignored
      do_req(1, 0, 0, 0);
      @(negedge clk);
      req_valid = 1'b1; req_ctrl = 2'd1; req_mode = 4'd6;
      req_ovr_en = 1'b1; req_ovr_phase = 5'd12;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      wait (q.size() == 0);
      repeat (2) @(negedge clk);
      chk(!busy && !wr_en, "R10", "busy|wr_en after ignored request",
          32'({busy, wr_en}), 32'd0);
      do_req(1, 2, 0, 0);
      wait (q.size() == 0);
      repeat (3) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end
endmodule